// File: doc/BRIEF.md
# Host Controller Interrupt Status and Enable Unit

This block gathers the event pulses of a USB host controller into one interrupt line. A single-cycle pulse on an event input latches a status bit. Software reads the status word over a small register port and acknowledges an event by writing 1 to its bit. Each source has an enable bit. Enables are never written directly. One address sets enable bits, a second address clears them, and a writable value of 0 at either address leaves the enables alone.

A master enable bit in the enable word gates every source at once. The interrupt line is a flop. It rises in the clock after a status/enable pairing appears, and it falls in the clock after the pairing goes away.

Top module: `usbh_irq_unit`

## Requirements
- R1: After reset the status word, the enable word (master bit included) and the interrupt output are all 0.
- R2: A 1 on event input k sets a status bit at the next clock edge. Inputs 0 to 6 map to status bits 0 to 6 (overrun, done-head written, start of frame, resume seen, fatal error, frame counter wrap, root hub change). Input 7 (ownership change) maps to bit 30. The status word is read at word address 0.
- R3: A write to address 0 clears every status bit 0 to 6 whose write-data bit is 1. Write-data bits that are 0 leave their status bit unchanged.
- R4: Software cannot clear status bit 30. Once set, it stays 1 until reset.
- R5: A write to address 1 sets every enable bit (0 to 6, 30, and master bit 31) whose write-data bit is 1. Other enable bits keep their value. The enable word is read at address 1.
- R6: A write to address 2 clears every enable bit whose write-data bit is 1. Reads of address 2 return 0.
- R7: The interrupt output in cycle n+1 equals master enable AND (OR over sources of status AND enable), taken from the register state of cycle n.
- R8: If an event pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Bits other than 0 to 6 and 30 in the status word, and other than 0 to 6, 30 and 31 in the enable word, read as 0. Writes of 1 to them are ignored.
- R10: Address 3 reads as 0. Writes to address 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word address: 0 status, 1 enable-set, 2 enable-clear, 3 unused |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_pulse | input | 8 | One event pulse per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A behavioural model in the bench follows status, enable and the interrupt line every cycle. Single pulses on each input show whether the bit mapping is right, especially the jump of source 7 to bit 30. Writes that carry a mix of ones and zeros to each address show whether writing 0 is truly neutral and whether set and clear go to the right word. Pulses that arrive in the same cycle as a clear of the same bit test the priority of the event. Writes of all ones to reserved bits and to the unused address test that those writes leave no trace. Walking the master bit and single enables show the gating and the one-cycle lag of the interrupt line.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        RA_STATUS  = 2'd0,
        RA_EN_SET  = 2'd1,
        RA_EN_CLR  = 2'd2,
        RA_UNUSED  = 2'd3
    } reg_addr_e;

    // Status position of event input idx: the low sources are packed from
    // bit 0, the last (hardware-owned) source sits at hi_pos.
    function automatic int unsigned src_bit(input int unsigned idx,
                                            input int unsigned n_src,
                                            input int unsigned hi_pos);
        return (idx == n_src - 1) ? hi_pos : idx;
    endfunction

endpackage

// File: rtl/usbh_irq_evt_map.sv
module usbh_irq_evt_map #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned HI_POS  = 30
) (
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [DATA_W-1:0]  set_o
);
    import usbh_irq_pkg::*;

    logic [DATA_W-1:0] spread [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int unsigned POS = src_bit(g, NUM_SRC, HI_POS);
        always_comb begin
            spread[g]      = '0;
            spread[g][POS] = evt_i[g];
        end
    end

    always_comb begin
        set_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            set_o = set_o | spread[i];
        end
    end

endmodule

// File: rtl/usbh_irq_status_bank.sv
module usbh_irq_status_bank #(
    parameter int unsigned      DATA_W   = 32,
    parameter logic [DATA_W-1:0] LIVE_MASK = '1,
    parameter logic [DATA_W-1:0] SW_MASK   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] hw_set,
    input  logic              sw_wr,
    input  logic [DATA_W-1:0] sw_data,
    output logic [DATA_W-1:0] status_o
);
    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } st_t;

    st_t st_d, st_q;
    logic [DATA_W-1:0] ack;

    always_comb begin
        st_d     = st_q;
        ack      = sw_wr ? (sw_data & SW_MASK) : '0;
        // event set is OR-ed last, so it wins over a same-cycle acknowledge
        st_d.bits = ((st_q.bits & ~ack) | hw_set) & LIVE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.bits;

    for (genvar b = 0; b < DATA_W; b++) begin : g_chk
        if (LIVE_MASK[b]) begin : g_live
            // R2 / R8: a pulse always lands, even against a clear
            a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                hw_set[b] |=> status_o[b]);
            if (SW_MASK[b]) begin : g_sw
                a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
                    (sw_wr && sw_data[b] && !hw_set[b]) |=> !status_o[b]);
            end else begin : g_hw
                a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                    status_o[b] |=> status_o[b]);
            end
        end else begin : g_dead
            a_r9_status_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
                !status_o[b]);
        end
    end

endmodule

// File: rtl/usbh_irq_enable_bank.sv
module usbh_irq_enable_bank #(
    parameter int unsigned       DATA_W  = 32,
    parameter logic [DATA_W-1:0] EN_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] enable_o
);
    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } en_t;

    en_t en_d, en_q;
    logic [DATA_W-1:0] up, down;

    always_comb begin
        en_d      = en_q;
        up        = set_wr ? (wdata & EN_MASK) : '0;
        down      = clr_wr ? wdata : '0;
        en_d.bits = ((en_q.bits | up) & ~down) & EN_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign enable_o = en_q.bits;

    for (genvar b = 0; b < DATA_W; b++) begin : g_chk
        if (EN_MASK[b]) begin : g_live
            a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
                (set_wr && wdata[b]) |=> enable_o[b]);
            a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_wr && wdata[b]) |=> !enable_o[b]);
            a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!(set_wr && wdata[b]) && !(clr_wr && wdata[b])) |=> $stable(enable_o[b]));
        end
    end

endmodule

// File: rtl/usbh_irq_read_mux.sv
module usbh_irq_read_mux #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] enable_i,
    output logic [DATA_W-1:0] rdata_o
);
    import usbh_irq_pkg::*;

    always_comb begin
        unique case (reg_addr_e'(addr))
            RA_STATUS: rdata_o = status_i;
            RA_EN_SET: rdata_o = enable_i;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/usbh_irq_unit.sv
module usbh_irq_unit #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned NUM_SRC    = 8,
    parameter int unsigned HI_POS     = 30,
    parameter int unsigned MASTER_POS = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    output logic               irq_o
);
    import usbh_irq_pkg::*;

    function automatic logic [DATA_W-1:0] src_mask_f();
        logic [DATA_W-1:0] m = '0;
        for (int i = 0; i < NUM_SRC; i++) m[src_bit(i, NUM_SRC, HI_POS)] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] SRC_MASK = src_mask_f();
    localparam logic [DATA_W-1:0] SW_MASK  = SRC_MASK & ~(DATA_W'(1) << HI_POS);
    localparam logic [DATA_W-1:0] EN_MASK  = SRC_MASK | (DATA_W'(1) << MASTER_POS);

    logic [DATA_W-1:0] hw_set, status_w, enable_w;
    logic              wr_status, wr_set, wr_clr;

    assign wr_status = reg_wr && (reg_addr == ADDR_W'(RA_STATUS));
    assign wr_set    = reg_wr && (reg_addr == ADDR_W'(RA_EN_SET));
    assign wr_clr    = reg_wr && (reg_addr == ADDR_W'(RA_EN_CLR));

    usbh_irq_evt_map #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .HI_POS(HI_POS)) u_map (
        .evt_i (evt_pulse),
        .set_o (hw_set)
    );

    usbh_irq_status_bank #(.DATA_W(DATA_W), .LIVE_MASK(SRC_MASK), .SW_MASK(SW_MASK)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_set   (hw_set),
        .sw_wr    (wr_status),
        .sw_data  (reg_wdata),
        .status_o (status_w)
    );

    usbh_irq_enable_bank #(.DATA_W(DATA_W), .EN_MASK(EN_MASK)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_wr   (wr_set),
        .clr_wr   (wr_clr),
        .wdata    (reg_wdata),
        .enable_o (enable_w)
    );

    usbh_irq_read_mux #(.DATA_W(DATA_W)) u_rd (
        .addr     (reg_addr),
        .status_i (status_w),
        .enable_i (enable_w),
        .rdata_o  (reg_rdata)
    );

    typedef struct packed {
        logic irq;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.irq = enable_w[MASTER_POS] && (|(status_w & enable_w & SRC_MASK));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_o = out_q.irq;

    // R7: master off silences the line one cycle later
    a_r7_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_w[MASTER_POS] |=> !irq_o);
    // R7: with no enabled pending source the line drops
    a_r7_no_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_w & enable_w & SRC_MASK) == '0) |=> !irq_o);
    // R6: the clear address never returns data
    a_r6_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(RA_EN_CLR)) |-> (reg_rdata == '0));
    // R10: the unused address changes nothing
    a_r10_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(RA_UNUSED) && evt_pulse == '0) |=> $stable(status_w) && $stable(enable_w));
    // R9: reserved enable bits stay 0
    a_r9_enable_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_w & ~EN_MASK) == '0);

endmodule

// File: tb/tb_usbh_irq_unit.sv
module tb_usbh_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_pulse = '0;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference state
    logic [31:0] m_stat = '0;
    logic [31:0] m_en   = '0;
    logic        m_irq  = 1'b0;

    usbh_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [1:0] a);
        if (a == 2'd0) return m_stat;
        if (a == 2'd1) return m_en;
        return 32'h0;
    endfunction

    // one cycle: drive at negedge, check the read path, advance, check irq
    task automatic step(input string req, input logic wr, input logic [1:0] a,
                        input logic [31:0] wd, input logic [7:0] ev);
        logic [31:0] setv;
        reg_wr = wr; reg_addr = a; reg_wdata = wd; evt_pulse = ev;
        #1;
        chk({req, " read"}, reg_rdata, m_read(a));
        @(posedge clk);
        m_irq = m_en[31] && ((m_stat & m_en & 32'h4000_007F) != 0);
        setv = {1'b0, ev[7], 23'b0, ev[6:0]};
        if (wr && a == 2'd0) m_stat = m_stat & ~(wd & 32'h0000_007F);
        m_stat = (m_stat | setv) & 32'h4000_007F;
        if (wr && a == 2'd1) m_en = m_en | (wd & 32'hC000_007F);
        if (wr && a == 2'd2) m_en = m_en & ~wd;
        @(negedge clk);
        chk({req, " irq"}, {31'b0, irq_o}, {31'b0, m_irq});
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 status", reg_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        step("R1", 0, 2'd1, 0, 0);

        // R2: each source alone
        for (int k = 0; k < 8; k++) begin
            step("R2 pulse", 0, 2'd0, 0, 8'(1 << k));
            step("R2 read", 0, 2'd0, 0, 0);
        end
        // R3: mixed ones and zeros, then zero write
        step("R3 clr mix", 1, 2'd0, 32'h0000_0055, 0);
        step("R3 read", 0, 2'd0, 0, 0);
        step("R3 zero write", 1, 2'd0, 32'h0, 0);
        step("R3 clr rest", 1, 2'd0, 32'h0000_002A, 0);
        // R4: ownership bit survives all-ones write
        step("R4 clr all", 1, 2'd0, 32'hFFFF_FFFF, 0);
        step("R4 read", 0, 2'd0, 0, 0);

        // R5: set enables without master, then add master
        step("R5 set", 1, 2'd1, 32'h0000_0003, 0);
        step("R5 zero write", 1, 2'd1, 32'h0, 0);
        step("R7 pending no master", 0, 2'd0, 0, 8'h01);
        step("R7 still no master", 0, 2'd1, 0, 0);
        step("R5 master", 1, 2'd1, 32'h8000_0000, 0);
        step("R7 rise", 0, 2'd1, 0, 0);
        step("R7 held", 0, 2'd0, 0, 0);
        // R6: disable master, reads zero at address 2
        step("R6 clr master", 1, 2'd2, 32'h8000_0000, 0);
        step("R6 read dis", 0, 2'd2, 0, 0);
        step("R7 fall", 0, 2'd1, 0, 0);
        step("R5 master again", 1, 2'd1, 32'h8000_0000, 0);
        step("R7 back", 0, 2'd0, 0, 0);
        // R3 clear drops irq
        step("R3 ack", 1, 2'd0, 32'h0000_0001, 0);
        step("R7 drop", 0, 2'd0, 0, 0);
        // R8: pulse and clear same bit same cycle
        step("R8 pulse", 0, 2'd0, 0, 8'h02);
        step("R8 race", 1, 2'd0, 32'h0000_0002, 8'h02);
        step("R8 read", 0, 2'd0, 0, 0);
        step("R8 race other", 1, 2'd0, 32'h0000_0002, 8'h04);
        step("R8 read2", 0, 2'd0, 0, 0);
        // R6: clear single enable with zeros elsewhere
        step("R6 clr bit1", 1, 2'd2, 32'h0000_0002, 0);
        step("R6 read en", 0, 2'd1, 0, 0);
        // ownership source through its enable
        step("R5 en oc", 1, 2'd1, 32'h4000_0000, 0);
        step("R7 oc", 0, 2'd1, 0, 0);
        // R9: reserved bits
        step("R9 set rsvd", 1, 2'd1, 32'h3FFF_FF80, 0);
        step("R9 read en", 0, 2'd1, 0, 0);
        step("R9 clr rsvd", 1, 2'd0, 32'h3FFF_FF80, 0);
        step("R9 read st", 0, 2'd0, 0, 0);
        // R10: unused address
        step("R10 write", 1, 2'd3, 32'hFFFF_FFFF, 0);
        step("R10 read", 0, 2'd3, 0, 0);
        step("R10 st", 0, 2'd0, 0, 0);
        step("R10 en", 0, 2'd1, 0, 0);
        // R6: clear everything
        step("R6 clr all", 1, 2'd2, 32'hFFFF_FFFF, 0);
        step("R6 read all", 0, 2'd1, 0, 0);
        step("R7 quiet", 0, 2'd0, 0, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule